// File: doc/BRIEF.md
# I/O Port Decoder and Audio Select

This block sits between the 8-bit I/O address space of a small game console's CPU and the registers that steer the console's memory map, its controller ports and its audio path. Each bus write is routed by address to a memory control register, a controller port control register, or an FM synthesizer enable latch. Read data for the upper sound/IO window is produced by combining the FM status byte with the data coming back from the controller ports.

A strap chooses between two decoding variants. In full-decode mode only one address pair reaches the control registers, and every write to the FM unit also mutes or unmutes all programmable sound generator (PSG) channels through data bit 1. In partial-decode mode the control registers are mirrored over their whole window and the PSG mask is left alone. A second strap says whether the FM unit is fitted. Read data is combinational on the address. Writes take effect at the rising clock edge on which the write strobe is high.

Top module: `io_port_decoder`

## Requirements
- R1: After reset the memory control register reads 0x00, the I/O control register 0xFF, the FM enable 0 and the PSG mask 0xFF.
- R2: Addresses with bits [7:6] = 00 form the control window. A write there with address bit 0 = 0 loads the memory control register, and with bit 0 = 1 it loads the I/O control register. In partial-decode mode every address of the window is accepted.
- R3: In full-decode mode only addresses 0x3E and 0x3F write the control registers. Writes to other control-window addresses leave both registers unchanged.
- R4: An FM access is an address with bits [7:6] = 11 and bit 2 = 0 while the FM-fitted strap is 1. An FM write loads data bit 0 into the FM enable. Upper-window writes that are not FM accesses leave it unchanged.
- R5: In full-decode mode an FM write sets the PSG mask to 0xFF when data bit 1 is 1 and to 0x00 when it is 0. In partial-decode mode the PSG mask never changes.
- R6: The FM status byte is 0xF8 OR the FM enable, so bits 2 and 1 always read 0.
- R7: In full-decode mode a read at an FM access address returns the FM status byte alone.
- R8: Every other read in the upper window starts from the FM status byte at an FM access address and from 0xFF elsewhere. When memory control bit 2 is 0, the controller read data is ANDed in. When it is 1, the controller data is excluded.
- R9: Addresses with bits [7:6] = 01 or 10 ignore writes. Reads there, and reads in the control window, return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| full_decode_i | input | 1 | Strap: 1 selects full decoding, 0 selects partial decoding with mirrors |
| fm_fitted_i | input | 1 | Strap: 1 when the FM unit is present |
| addr_i | input | 8 | CPU I/O port address |
| wdata_i | input | 8 | CPU write data |
| wr_i | input | 1 | Write strobe, one cycle per write |
| pad_rdata_i | input | 8 | Read data from the controller ports |
| rdata_o | output | 8 | Read data for the current address |
| memctl_o | output | 8 | Memory control register |
| ioctl_o | output | 8 | I/O control register |
| fm_enable_o | output | 1 | FM output enable latch |
| psg_mask_o | output | 8 | PSG channel enable mask |

## Verification
All 256 addresses are swept with writes and reads under each of the four strap combinations, so the mirror pattern of the control window and the full-decode exception at 0x3E/0x3F show up address by address. Write data varies with the address, which sets and clears FM enable bit 0 and PSG bit 1 in both polarities. The reads are repeated with memory control bit 2 set and clear, and with two complementary controller data patterns. This separates an AND merge from an OR merge or a pass-through, and shows whether the FM status byte is returned alone or merged with the controller data.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;

  typedef struct packed {
    logic ctrl_hit;   // control register write target
    logic ctrl_io;    // 1: I/O control, 0: memory control
    logic upper;      // upper sound/IO window
    logic fm_hit;     // FM unit access
  } dec_t;

endpackage

// File: rtl/io_addr_decode.sv
module io_addr_decode
  import io_dec_pkg::*;
#(
  parameter int ADDR_W         = 8,
  parameter int FULL_CTRL_BASE = 8'h3E,
  parameter int FM_SEL_BIT     = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              full_decode_i,
  input  logic              fm_fitted_i,
  output dec_t              dec_o
);

  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(FULL_CTRL_BASE);

  logic [1:0] win;
  logic       full_match;

  always_comb begin
    win        = addr_i[ADDR_W-1 -: 2];
    full_match = (addr_i[ADDR_W-1:1] == BASE[ADDR_W-1:1]);
    dec_o.ctrl_hit = (win == 2'b00) && (!full_decode_i || full_match);
    dec_o.ctrl_io  = addr_i[0];
    dec_o.upper    = (win == 2'b11);
    dec_o.fm_hit   = (win == 2'b11) && !addr_i[FM_SEL_BIT] && fm_fitted_i;
  end

endmodule

// File: rtl/io_ctrl_regs.sv
module io_ctrl_regs
  import io_dec_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  dec_t              dec_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] memctl_q,
  output logic [DATA_W-1:0] ioctl_q
);

  logic              mem_en, io_en;
  logic [DATA_W-1:0] memctl_d, ioctl_d;

  always_comb begin
    mem_en   = wr_i && dec_i.ctrl_hit && !dec_i.ctrl_io;
    io_en    = wr_i && dec_i.ctrl_hit &&  dec_i.ctrl_io;
    memctl_d = mem_en ? wdata_i : memctl_q;
    ioctl_d  = io_en  ? wdata_i : ioctl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      memctl_q <= '0;
      ioctl_q  <= '1;
    end else begin
      memctl_q <= memctl_d;
      ioctl_q  <= ioctl_d;
    end
  end

  // R3
  ctrl_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_i.ctrl_hit) |=> ($stable(memctl_q) && $stable(ioctl_q)));

  // R2
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && dec_i.ctrl_hit && dec_i.ctrl_io) |=> (ioctl_q == $past(wdata_i)));

endmodule

// File: rtl/io_audio_latch.sv
module io_audio_latch #(
  parameter int PSG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic             fm_hit_i,
  input  logic             full_decode_i,
  input  logic             fm_bit_i,
  input  logic             psg_bit_i,
  output logic             fm_en_q,
  output logic [PSG_W-1:0] psg_mask_q
);

  logic             fm_we, psg_we;
  logic             fm_en_d;
  logic [PSG_W-1:0] psg_mask_d;

  always_comb begin
    fm_we      = wr_i && fm_hit_i;
    psg_we     = fm_we && full_decode_i;
    fm_en_d    = fm_we ? fm_bit_i : fm_en_q;
    psg_mask_d = psg_we ? {PSG_W{psg_bit_i}} : psg_mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fm_en_q    <= 1'b0;
      psg_mask_q <= '1;
    end else begin
      fm_en_q    <= fm_en_d;
      psg_mask_q <= psg_mask_d;
    end
  end

  // R4
  fm_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && fm_hit_i) |=> (fm_en_q == $past(fm_bit_i)));

  // R5
  psg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_decode_i) |=> $stable(psg_mask_q));

  // R5
  psg_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psg_mask_q == '0) || (psg_mask_q == '1));

endmodule

// File: rtl/io_read_merge.sv
module io_read_merge
  import io_dec_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  dec_t              dec_i,
  input  logic              full_decode_i,
  input  logic              fm_en_i,
  input  logic              pad_dis_i,
  input  logic [DATA_W-1:0] pad_rdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int HI_W = DATA_W - 3;

  logic [DATA_W-1:0] status, base;

  always_comb begin
    status  = {{HI_W{1'b1}}, 2'b00, fm_en_i};
    base    = dec_i.fm_hit ? status : '1;
    rdata_o = '1;
    if (dec_i.upper) begin
      if (full_decode_i && dec_i.fm_hit) rdata_o = status;
      else if (pad_dis_i)                rdata_o = base;
      else                               rdata_o = base & pad_rdata_i;
    end
  end

  // R7
  always_comb begin
    if (full_decode_i && dec_i.fm_hit)
      fm_only_chk: assert (rdata_o == {{HI_W{1'b1}}, 2'b00, fm_en_i});
  end

  // R9
  always_comb begin
    if (!dec_i.upper)
      idle_read_chk: assert (rdata_o == '1);
  end

endmodule

// File: rtl/io_port_decoder.sv
module io_port_decoder
  import io_dec_pkg::*;
#(
  parameter int ADDR_W         = 8,
  parameter int DATA_W         = 8,
  parameter int PSG_W          = 8,
  parameter int FULL_CTRL_BASE = 8'h3E,
  parameter int FM_SEL_BIT     = 2,
  parameter int PAD_DIS_BIT    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              full_decode_i,
  input  logic              fm_fitted_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] pad_rdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] memctl_o,
  output logic [DATA_W-1:0] ioctl_o,
  output logic              fm_enable_o,
  output logic [PSG_W-1:0]  psg_mask_o
);

  dec_t dec;

  io_addr_decode #(
    .ADDR_W(ADDR_W), .FULL_CTRL_BASE(FULL_CTRL_BASE), .FM_SEL_BIT(FM_SEL_BIT)
  ) u_dec (
    .addr_i(addr_i), .full_decode_i(full_decode_i),
    .fm_fitted_i(fm_fitted_i), .dec_o(dec)
  );

  io_ctrl_regs #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_i), .dec_i(dec), .wdata_i(wdata_i),
    .memctl_q(memctl_o), .ioctl_q(ioctl_o)
  );

  io_audio_latch #(.PSG_W(PSG_W)) u_audio (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_i), .fm_hit_i(dec.fm_hit),
    .full_decode_i(full_decode_i), .fm_bit_i(wdata_i[0]),
    .psg_bit_i(wdata_i[1]), .fm_en_q(fm_enable_o), .psg_mask_q(psg_mask_o)
  );

  io_read_merge #(.DATA_W(DATA_W)) u_rd (
    .dec_i(dec), .full_decode_i(full_decode_i), .fm_en_i(fm_enable_o),
    .pad_dis_i(memctl_o[PAD_DIS_BIT]), .pad_rdata_i(pad_rdata_i),
    .rdata_o(rdata_o)
  );

  // R9
  mid_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i[ADDR_W-1 -: 2] inside {2'b01, 2'b10}) |=>
      ($stable(memctl_o) && $stable(ioctl_o) && $stable(fm_enable_o) && $stable(psg_mask_o)));

  // R6
  fm_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.fm_hit && full_decode_i) |-> (rdata_o[2:1] == 2'b00));

endmodule

// File: tb/io_port_decoder_tb.sv
module io_port_decoder_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       full_decode_i, fm_fitted_i, wr_i;
  logic [7:0] addr_i, wdata_i, pad_rdata_i;
  logic [7:0] rdata_o, memctl_o, ioctl_o, psg_mask_o;
  logic       fm_enable_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [7:0] m_mem, m_io, m_psg;
  logic       m_fm;

  always #2.5 clk = ~clk;

  io_port_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .full_decode_i(full_decode_i),
    .fm_fitted_i(fm_fitted_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_i(wr_i), .pad_rdata_i(pad_rdata_i), .rdata_o(rdata_o),
    .memctl_o(memctl_o), .ioctl_o(ioctl_o), .fm_enable_o(fm_enable_o),
    .psg_mask_o(psg_mask_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h (addr=%02h full=%0b fm=%0b)",
               req, act, exp, addr_i, full_decode_i, fm_fitted_i);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_i = 1'b0; addr_i = 8'h80; wdata_i = 8'h00;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    m_mem = 8'h00; m_io = 8'hFF; m_fm = 1'b0; m_psg = 8'hFF;
    @(negedge clk);
  endtask

  function automatic logic [7:0] exp_read(input logic [7:0] a, input logic [7:0] pad);
    logic fmh;
    logic [7:0] st, b;
    fmh = (a[7:6] == 2'b11) && !a[2] && fm_fitted_i;
    st  = 8'hF8 | {7'd0, m_fm};
    if (a[7:6] != 2'b11) return 8'hFF;             // R9
    if (full_decode_i && fmh) return st;           // R7
    b = fmh ? st : 8'hFF;                          // R8
    return m_mem[2] ? b : (b & pad);
  endfunction

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk);
    wr_i = 1'b0;
    if (a[7:6] == 2'b00 && (!full_decode_i || a[7:1] == 7'h1F)) begin
      if (a[0]) m_io = d; else m_mem = d;
    end
    if (a[7:6] == 2'b11 && !a[2] && fm_fitted_i) begin
      m_fm = d[0];
      if (full_decode_i) m_psg = d[1] ? 8'hFF : 8'h00;
    end
  endtask

  task automatic read_check(input logic [7:0] a, input logic [7:0] pad);
    logic fmh;
    addr_i = a; pad_rdata_i = pad;
    #1;
    fmh = (a[7:6] == 2'b11) && !a[2] && fm_fitted_i;
    if (a[7:6] != 2'b11)           check("R9 read", rdata_o, exp_read(a, pad));
    else if (full_decode_i && fmh) check("R7 R6 read", rdata_o, exp_read(a, pad));
    else                           check("R8 read", rdata_o, exp_read(a, pad));
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; wr_i = 1'b0; addr_i = 8'h00; wdata_i = 8'h00;
    pad_rdata_i = 8'hFF; full_decode_i = 1'b0; fm_fitted_i = 1'b1;
    for (int mode = 0; mode < 4; mode++) begin
      full_decode_i = mode[0];
      fm_fitted_i   = mode[1];
      do_reset();
      check("R1 memctl", memctl_o, 8'h00);
      check("R1 ioctl", ioctl_o, 8'hFF);
      check("R1 fm", {7'd0, fm_enable_o}, 8'h00);
      check("R1 psg", psg_mask_o, 8'hFF);
      for (int a = 0; a < 256; a++) begin
        logic [7:0] d;
        d = 8'(a * 37 + mode * 11) ^ 8'h5A;
        bus_write(8'(a), d);
        if (a < 64) begin
          check("R2 R3 memctl", memctl_o, m_mem);
          check("R2 R3 ioctl", ioctl_o, m_io);
        end else if (a >= 192) begin
          check("R4 fm", {7'd0, fm_enable_o}, {7'd0, m_fm});
          check("R5 psg", psg_mask_o, m_psg);
        end else begin
          check("R9 memctl", memctl_o, m_mem);
          check("R9 ioctl", ioctl_o, m_io);
          check("R9 fm", {7'd0, fm_enable_o}, {7'd0, m_fm});
          check("R9 psg", psg_mask_o, m_psg);
        end
      end
      for (int p = 0; p < 2; p++) begin
        bus_write(8'h3E, p[0] ? 8'h04 : 8'h00);   // memctl bit 2
        for (int f = 0; f < 2; f++) begin
          bus_write(8'hF0, {6'd0, 1'b1, f[0]});    // fm enable, psg on
          for (int a = 0; a < 256; a++) begin
            read_check(8'(a), 8'hA5);
            read_check(8'(a), 8'h5A);
          end
        end
      end
      check("R5 final psg", psg_mask_o, m_psg);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule